// File: doc/BRIEF.md
# Low-Power Mode Wake-up Controller

This block decides when a system basis chip leaves its two low-power states, Stop and Sleep. Five event inputs (local wake pins, cyclic-sense result, forced-wake timer, chip select, LIN bus wake) each have an enable bit. The current mode sets which of them are eligible. When an eligible, enabled event is seen, the block issues a single-cycle mode-change pulse with the target mode. It also sets a sticky flag for each source that fired and pulses a wake interrupt.

A separate path watches the active-low reset pin. The pin counts as a wake only in Stop, and only after it has been sampled low on a parameterised number of consecutive clock edges. It raises no interrupt and sets no flag. Its target mode depends on whether the watchdog is configured active. The mode register itself lives outside the block. After issuing a mode change, the block stays disarmed until the current mode leaves the low-power states.

Top module: `lpw_wake_ctrl`

## Requirements
- R1: In Stop mode (cur_mode 2'b10), all five event sources are eligible: bit0 local pins, bit1 cyclic sense, bit2 forced wake, bit3 chip select, bit4 LIN.
- R2: In Sleep mode (cur_mode 2'b11), the chip-select source (bit3) and the reset pin are ignored. Bits 0, 1, 2 and 4 are eligible.
- R3: In Normal (2'b00) and Normal Request (2'b01) modes, every event and the reset pin are ignored: no pulse and no flag change.
- R4: An event whose enable bit is 0 has no effect in any mode.
- R5: One clock edge after an eligible, enabled event is sampled, wake_go and wake_irq are high for exactly one cycle and wake_mode is Normal Request (2'b01). The source's wake_flags bit is set and stays set.
- R6: A flag_clr pulse clears all wake_flags bits. A flag being set in the same cycle wins over the clear.
- R7: Events sampled in the same cycle set all of their flags and produce a single wake_go pulse. No further wake_go is issued until cur_mode has left Stop and Sleep.
- R8: A reset-pin wake occurs only after rst_pin_n is sampled low on FILT_CYC consecutive edges while in Stop. A high sample restarts the count.
- R9: A reset-pin wake gives wake_mode Normal Request (2'b01) when wd_active is 1 and Normal (2'b00) when it is 0.
- R10: A reset-pin wake pulses wake_go but neither wake_irq nor any wake_flags bit.
- R11: After reset, wake_go and wake_irq are 0 and wake_flags is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_mode | input | 2 | Current operating mode: 00 Normal, 01 Normal Request, 10 Stop, 11 Sleep |
| wd_active | input | 1 | Watchdog configured active |
| wake_src | input | NSRC | Wake event inputs, bit order as in R1 |
| wake_en | input | NSRC | Per-source enable bits |
| rst_pin_n | input | 1 | Reset pin level, active low |
| flag_clr | input | 1 | Read-clear strobe for wake_flags |
| wake_go | output | 1 | One-cycle mode change request |
| wake_mode | output | 2 | Target mode while wake_go is high |
| wake_irq | output | 1 | One-cycle wake interrupt pulse |
| wake_flags | output | NSRC | Sticky per-source wake flags |

## Verification
Wrong eligibility or gating state shows up on the edge right after the event: a missing or extra wake_go or wake_irq pulse, or a wrong flag bit. A lost disarm shows up as a second wake_go on the following cycle. A reset-pin counter that is off by one shifts the wake_go edge by one cycle. A counter that fails to restart lets a broken low pulse through. Both are caught by checking every cycle of the low interval.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
   typedef enum logic [1:0] {
      LPW_NORMAL = 2'b00,
      LPW_NREQ   = 2'b01,
      LPW_STOP   = 2'b10,
      LPW_SLEEP  = 2'b11
   } lpw_mode_e;

   localparam int LPW_NSRC   = 5;
   localparam int LPW_SRC_CS = 3;
endpackage

// File: rtl/lpw_pin_filter.sv
module lpw_pin_filter #(
   parameter int FILT_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic pin_n,
   output logic fire
);
   localparam int CNT_W = $clog2(FILT_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (FILT_CYC < 2) begin : g_bad
         $error("lpw_pin_filter: FILT_CYC must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || pin_n)
         cnt_q <= '0;
      else if (cnt_q != LAST)
         cnt_q <= cnt_q + 1'b1;
   end

   assign fire = run && !pin_n && (cnt_q == LAST);
endmodule

// File: rtl/lpw_src_gate.sv
module lpw_src_gate #(
   parameter int               NSRC       = 5,
   parameter logic [NSRC-1:0]  STOP_MASK  = '1,
   parameter logic [NSRC-1:0]  SLEEP_MASK = '1
) (
   input  logic [1:0]      cur_mode,
   input  logic            armed,
   input  logic [NSRC-1:0] evt,
   input  logic [NSRC-1:0] en,
   output logic [NSRC-1:0] hit
);
   import lpw_pkg::*;

   logic in_stop, in_sleep;
   assign in_stop  = (cur_mode == LPW_STOP);
   assign in_sleep = (cur_mode == LPW_SLEEP);

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         if (STOP_MASK[i] && SLEEP_MASK[i]) begin : g_both
            assign hit[i] = armed & evt[i] & en[i] & (in_stop | in_sleep);
         end else if (STOP_MASK[i]) begin : g_stop
            assign hit[i] = armed & evt[i] & en[i] & in_stop;
         end else if (SLEEP_MASK[i]) begin : g_sleep
            assign hit[i] = armed & evt[i] & en[i] & in_sleep;
         end else begin : g_none
            assign hit[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/lpw_flag_bank.sv
module lpw_flag_bank #(
   parameter int NSRC = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set,
   input  logic            clr,
   output logic [NSRC-1:0] flags
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags <= '0;
      else
         flags <= (clr ? '0 : flags) | set;
   end
endmodule

// File: rtl/lpw_wake_ctrl.sv
module lpw_wake_ctrl #(
   parameter int              FILT_CYC   = 16,
   parameter int              NSRC       = lpw_pkg::LPW_NSRC,
   parameter logic [NSRC-1:0] STOP_MASK  = '1,
   parameter logic [NSRC-1:0] SLEEP_MASK = ~(NSRC'(1) << lpw_pkg::LPW_SRC_CS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cur_mode,
   input  logic            wd_active,
   input  logic [NSRC-1:0] wake_src,
   input  logic [NSRC-1:0] wake_en,
   input  logic            rst_pin_n,
   input  logic            flag_clr,
   output logic            wake_go,
   output logic [1:0]      wake_mode,
   output logic            wake_irq,
   output logic [NSRC-1:0] wake_flags
);
   import lpw_pkg::*;

   generate
      if (NSRC < 1 || NSRC > 16) begin : g_bad_nsrc
         $error("lpw_wake_ctrl: NSRC out of range");
      end
   endgenerate

   logic            armed_q;
   logic [NSRC-1:0] hit;
   logic            any_hit;
   logic            pin_fire;
   logic            lp_mode;

   assign lp_mode = cur_mode[1];

   lpw_src_gate #(
      .NSRC      (NSRC),
      .STOP_MASK (STOP_MASK),
      .SLEEP_MASK(SLEEP_MASK)
   ) u_gate (
      .cur_mode(cur_mode),
      .armed   (armed_q),
      .evt     (wake_src),
      .en      (wake_en),
      .hit     (hit)
   );

   lpw_pin_filter #(
      .FILT_CYC(FILT_CYC)
   ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (armed_q && (cur_mode == LPW_STOP)),
      .pin_n(rst_pin_n),
      .fire (pin_fire)
   );

   lpw_flag_bank #(
      .NSRC(NSRC)
   ) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (hit),
      .clr  (flag_clr),
      .flags(wake_flags)
   );

   assign any_hit = |hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b1;
         wake_go   <= 1'b0;
         wake_irq  <= 1'b0;
         wake_mode <= LPW_NREQ;
      end else begin
         wake_go  <= any_hit | pin_fire;
         wake_irq <= any_hit;
         if (pin_fire)
            wake_mode <= wd_active ? LPW_NREQ : LPW_NORMAL;
         else if (any_hit)
            wake_mode <= LPW_NREQ;
         if (!lp_mode)
            armed_q <= 1'b1;
         else if (any_hit | pin_fire)
            armed_q <= 1'b0;
      end
   end
endmodule

// File: rtl/lpw_wake_chk.sv
module lpw_wake_chk #(
   parameter int NSRC = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      cur_mode,
   input logic            wd_active,
   input logic            wake_go,
   input logic [1:0]      wake_mode,
   input logic            wake_irq,
   input logic [NSRC-1:0] wake_flags
);
   // R5: interrupt only accompanies a mode change
   assert_irq_with_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> wake_go);

   // R3: a mode change only follows a low-power mode
   assert_go_from_lp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_go |-> $past(cur_mode[1]));

   // R7: one pulse per wake
   assert_single_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_go |=> !wake_go);

   // R2: chip-select flag never rises from Sleep
   assert_no_cs_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'b11) |=> !$rose(wake_flags[3]));

   // R10: new flags always come with the interrupt
   assert_flag_needs_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((wake_flags & ~$past(wake_flags)) != '0) |-> wake_irq);

   // R9: a wake without interrupt is a reset-pin wake
   assert_pin_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_go && !wake_irq) |-> (wake_mode == ($past(wd_active) ? 2'b01 : 2'b00)));
endmodule

bind lpw_wake_ctrl lpw_wake_chk #(.NSRC(NSRC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cur_mode  (cur_mode),
   .wd_active (wd_active),
   .wake_go   (wake_go),
   .wake_mode (wake_mode),
   .wake_irq  (wake_irq),
   .wake_flags(wake_flags)
);

// File: tb/sim_lpw_wake_ctrl.sv
`timescale 1ns/1ps
module sim_lpw_wake_ctrl;
   localparam int FILT = 4;
   localparam int NS   = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cur_mode = 2'b00;
   logic          wd_active = 1'b1;
   logic [NS-1:0] wake_src = '0;
   logic [NS-1:0] wake_en = '0;
   logic          rst_pin_n = 1'b1;
   logic          flag_clr = 1'b0;
   logic          wake_go;
   logic [1:0]    wake_mode;
   logic          wake_irq;
   logic [NS-1:0] wake_flags;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lpw_wake_ctrl #(.FILT_CYC(FILT)) u0 (
      .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .wd_active(wd_active),
      .wake_src(wake_src), .wake_en(wake_en), .rst_pin_n(rst_pin_n),
      .flag_clr(flag_clr), .wake_go(wake_go), .wake_mode(wake_mode),
      .wake_irq(wake_irq), .wake_flags(wake_flags)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // leave low power, clear flags, then enter mode m
   task automatic arm(logic [1:0] m);
      cur_mode = 2'b00; flag_clr = 1'b1; wake_src = '0; rst_pin_n = 1'b1;
      step();
      flag_clr = 1'b0; cur_mode = m;
      step();
   endtask

   initial begin
      #20000;
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(); step();
      // R11
      chk("R11 go", wake_go, 0);
      chk("R11 irq", wake_irq, 0);
      chk("R11 flags", wake_flags, 0);
      rst_n = 1'b1;
      step();

      // R1 R2 R3 R4 R5: sweep mode x source x enable
      for (int m = 0; m < 4; m++)
         for (int s = 0; s < NS; s++)
            for (int e = 0; e < 2; e++) begin
               bit elig, hit;
               arm(2'(m));
               elig = (m == 2) || (m == 3 && s != 3);
               hit  = elig && (e == 1);
               wake_en = NS'(e) << s;
               wake_src = NS'(1) << s;
               step();
               wake_src = '0;
               chk("R1/R2/R3/R4 go", wake_go, hit);
               chk("R5 irq", wake_irq, hit);
               chk("R5 flags", wake_flags, hit ? (1 << s) : 0);
               if (hit) chk("R5 mode", wake_mode, 1);
               step();
               chk("R5 go one cycle", wake_go, 0);
               chk("R5 flag sticky", wake_flags, hit ? (1 << s) : 0);
            end

      // R6 clear, and set wins over clear
      arm(2'b10);
      wake_en = '1; wake_src = 5'b00001;
      step();
      wake_src = '0; flag_clr = 1'b1;
      step();
      flag_clr = 1'b0;
      chk("R6 clear", wake_flags, 0);
      arm(2'b10);
      wake_src = 5'b00100; flag_clr = 1'b1;
      step();
      wake_src = '0; flag_clr = 1'b0;
      chk("R6 set wins", wake_flags, 5'b00100);

      // R7 simultaneous events, disarm until leaving low power
      arm(2'b10);
      wake_en = '1; wake_src = '1;
      step();
      chk("R7 all flags", wake_flags, 5'b11111);
      chk("R7 go", wake_go, 1);
      step();
      chk("R7 single go", wake_go, 0);
      step();
      chk("R7 disarmed", wake_go, 0);
      wake_src = '0;

      // R8 R9 R10 reset-pin filter, both watchdog settings and modes
      for (int wd = 0; wd < 2; wd++)
         for (int m = 2; m < 4; m++) begin
            arm(2'(m));
            wd_active = wd[0];
            rst_pin_n = 1'b0;
            for (int i = 0; i < FILT + 2; i++) begin
               bit exp_go;
               step();
               exp_go = (m == 2) && (i == FILT - 1);
               chk("R8/R2 pin go", wake_go, exp_go);
               chk("R10 irq", wake_irq, 0);
               chk("R10 flags", wake_flags, 0);
               if (exp_go) chk("R9 mode", wake_mode, wd ? 1 : 0);
            end
            rst_pin_n = 1'b1;
         end

      // R8 restart: two short low pulses
      arm(2'b10);
      for (int k = 0; k < 2; k++) begin
         rst_pin_n = 1'b0;
         for (int i = 0; i < FILT - 1; i++) begin
            step();
            chk("R8 short low", wake_go, 0);
         end
         rst_pin_n = 1'b1;
         step();
         chk("R8 restart", wake_go, 0);
      end

      // R3 reset pin ignored in Normal Request
      arm(2'b01);
      rst_pin_n = 1'b0;
      for (int i = 0; i < FILT + 1; i++) begin
         step();
         chk("R3 pin in normal", wake_go, 0);
      end
      rst_pin_n = 1'b1;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule